// File: doc/BRIEF.md
# Flagged Port Mailbox with Condition-Triggered Routine Dispatch

This block holds an array of one-word mailboxes. Each is a 32-bit data register paired with a full/empty flag. Both the processor core and external peripherals share the mailboxes. The core reaches them through conditional accesses:
- A conditional write lands only in an empty mailbox.
- A conditional read succeeds only on a full mailbox.

Each conditional access reports success or failure in the same cycle. Peripherals use a plain request/response path. A peripheral write sets the data word and sets the flag to a value the peripheral chooses. A peripheral read returns the data word and the flag.

The block also keeps a small table of routines. Each entry holds an enable bit, a start and an end program counter, and two port masks. One mask lists the ports that must be full and the other lists the ports that must be empty. While no routine is running, the block picks the lowest-numbered eligible routine. It then steps the program counter one address per cycle from the start address to the end address, with no branching. Mailbox traffic between routines therefore drives the scheduling, instead of branch instructions.

Top module: `port_mailbox_sched`

## Requirements
- R1: After reset every port flag is empty (port_full all zero) and no routine is running (run_busy low).
- R2: A core write (core_req=1, core_wr=1) to an empty port reports core_ok=1 in that cycle. At the next edge it stores core_wdata and sets the flag to full.
- R3: A core write to a full port reports core_ok=0 and leaves that port's data and flag unchanged.
- R4: A core read (core_req=1, core_wr=0) of a full port reports core_ok=1 and returns the stored word on core_rdata. At the next edge the flag becomes empty.
- R5: A core read of an empty port reports core_ok=0 and leaves the flag empty.
- R6: A peripheral write (per_req=1, per_wr=1) stores per_wdata and sets the flag to per_flag at the next edge. A peripheral read (per_wr=0) shows the word on per_rdata and the flag on per_rfull, and changes neither.
- R7: When a core access and a peripheral access name the same port in one cycle, the peripheral access takes effect and core_ok is 0.
- R8: A routine is eligible when it is enabled, every port in its need-full mask is full, and every port in its need-empty mask is empty. When the block is idle and a routine is eligible, at the next edge run_busy rises, run_pc equals that routine's start address and run_id equals its index.
- R9: While running, run_pc advances by one per cycle. At the edge after run_pc equals the end address, run_busy falls.
- R10: When several routines are eligible at once, the lowest index is dispatched.
- R11: No routine is dispatched while one is running. Eligibility is evaluated again in the idle cycle that follows the end, so back-to-back routines are separated by exactly one idle cycle.
- R12: A configuration write (cfg_we=1) loads the entry at cfg_idx, and it applies from the next cycle. A disabled entry is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load a routine table entry |
| cfg_idx | input | 3 | Entry index to load |
| cfg_en | input | 1 | Entry enable |
| cfg_start | input | 12 | Start program counter |
| cfg_end | input | 12 | End program counter (not below start) |
| cfg_need_full | input | 128 | Ports that must be full |
| cfg_need_empty | input | 128 | Ports that must be empty |
| core_req | input | 1 | Core conditional access request |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | 7 | Core port number |
| core_wdata | input | 32 | Core write data |
| core_ok | output | 1 | Core access succeeded |
| core_rdata | output | 32 | Data of the addressed port |
| per_req | input | 1 | Peripheral access request |
| per_wr | input | 1 | 1 = write, 0 = read |
| per_addr | input | 7 | Peripheral port number |
| per_wdata | input | 32 | Peripheral write data |
| per_flag | input | 1 | Flag value written by a peripheral write |
| per_rdata | output | 32 | Data of the peripheral-addressed port |
| per_rfull | output | 1 | Flag of the peripheral-addressed port |
| port_full | output | 128 | All port flags |
| run_busy | output | 1 | A routine is running |
| run_id | output | 3 | Index of the running routine |
| run_pc | output | 12 | Current program counter |

## Verification
The mailbox path gets thousands of random mixed core and peripheral operations, confined to eight ports so that collisions, full-port writes and empty-port reads happen often. A bench-side flag and data model separates the success rules from the peripheral-wins arbitration. The dispatcher gets a directed sequence that first holds one condition back, then meets it. During a run it makes a second, lower-indexed routine eligible, and later disables that routine. This sequence separates the full/empty mask test, the exact start-to-end stepping, the single idle cycle between routines, lowest-index priority and the effect of the enable bit.

// File: rtl/port_mailbox_sched.sv
module port_mailbox_sched #(
  parameter int NPORTS = 128,
  parameter int NRT    = 8,
  parameter int PCW    = 12,
  parameter int DW     = 32,
  localparam int AW    = $clog2(NPORTS),
  localparam int RW    = $clog2(NRT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RW-1:0]     cfg_idx,
  input  logic              cfg_en,
  input  logic [PCW-1:0]    cfg_start,
  input  logic [PCW-1:0]    cfg_end,
  input  logic [NPORTS-1:0] cfg_need_full,
  input  logic [NPORTS-1:0] cfg_need_empty,
  input  logic              core_req,
  input  logic              core_wr,
  input  logic [AW-1:0]     core_addr,
  input  logic [DW-1:0]     core_wdata,
  output logic              core_ok,
  output logic [DW-1:0]     core_rdata,
  input  logic              per_req,
  input  logic              per_wr,
  input  logic [AW-1:0]     per_addr,
  input  logic [DW-1:0]     per_wdata,
  input  logic              per_flag,
  output logic [DW-1:0]     per_rdata,
  output logic              per_rfull,
  output logic [NPORTS-1:0] port_full,
  output logic              run_busy,
  output logic [RW-1:0]     run_id,
  output logic [PCW-1:0]    run_pc
);

  logic [DW-1:0]     mem [NPORTS];
  logic [NPORTS-1:0] full;

  logic [NRT-1:0]    rt_en;
  logic [PCW-1:0]    rt_start [NRT];
  logic [PCW-1:0]    rt_end   [NRT];
  logic [NPORTS-1:0] rt_nf    [NRT];
  logic [NPORTS-1:0] rt_ne    [NRT];

  logic [NRT-1:0]    elig;
  logic [RW-1:0]     pick;
  logic [PCW-1:0]    cur_end;
  logic              clash;

  assign clash      = per_req && (per_addr == core_addr);
  assign core_ok    = core_req && !clash && (core_wr ? !full[core_addr] : full[core_addr]);
  assign core_rdata = mem[core_addr];
  assign per_rdata  = mem[per_addr];
  assign per_rfull  = full[per_addr];
  assign port_full  = full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
      for (int i = 0; i < NPORTS; i++) mem[i] <= '0;
    end else begin
      if (core_ok) begin
        if (core_wr) begin
          mem[core_addr]  <= core_wdata;
          full[core_addr] <= 1'b1;
        end else begin
          full[core_addr] <= 1'b0;
        end
      end
      if (per_req && per_wr) begin
        mem[per_addr]  <= per_wdata;
        full[per_addr] <= per_flag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_en <= '0;
      for (int i = 0; i < NRT; i++) begin
        rt_start[i] <= '0;
        rt_end[i]   <= '0;
        rt_nf[i]    <= '0;
        rt_ne[i]    <= '0;
      end
    end else if (cfg_we) begin
      rt_en[cfg_idx]    <= cfg_en;
      rt_start[cfg_idx] <= cfg_start;
      rt_end[cfg_idx]   <= cfg_end;
      rt_nf[cfg_idx]    <= cfg_need_full;
      rt_ne[cfg_idx]    <= cfg_need_empty;
    end
  end

  for (genvar g = 0; g < NRT; g++) begin : g_elig
    assign elig[g] = rt_en[g] && ((full & rt_nf[g]) == rt_nf[g]) && ((~full & rt_ne[g]) == rt_ne[g]);
  end

  always_comb begin
    pick = '0;
    for (int i = NRT - 1; i >= 0; i--)
      if (elig[i]) pick = RW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_busy <= 1'b0;
      run_pc   <= '0;
      run_id   <= '0;
      cur_end  <= '0;
    end else if (run_busy) begin
      if (run_pc == cur_end) run_busy <= 1'b0;
      else                   run_pc   <= run_pc + 1'b1;
    end else if (|elig) begin
      run_busy <= 1'b1;
      run_pc   <= rt_start[pick];
      cur_end  <= rt_end[pick];
      run_id   <= pick;
    end
  end

  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    core_ok && core_wr |=> full[$past(core_addr)]); // R2
  AST_WR_FULL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_wr && !per_req && full[core_addr] |=> $stable(full) && mem[$past(core_addr)] == $past(core_rdata)); // R3
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    core_ok && !core_wr |=> !full[$past(core_addr)]); // R4
  AST_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && per_wr |=> full[$past(per_addr)] == $past(per_flag)); // R6
  AST_PER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && per_req && core_addr == per_addr |-> !core_ok); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_busy && run_pc != cur_end |=> run_busy && run_pc == $past(run_pc) + 1'b1); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_busy && run_pc == cur_end |=> !run_busy); // R11
  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !run_busy && elig[0] |=> run_busy && run_id == '0); // R10

endmodule

// File: tb/port_mailbox_sched_tb.sv
module port_mailbox_sched_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         cfg_we, cfg_en;
  logic [2:0]   cfg_idx;
  logic [11:0]  cfg_start, cfg_end;
  logic [127:0] cfg_need_full, cfg_need_empty;
  logic         core_req, core_wr, core_ok;
  logic [6:0]   core_addr, per_addr;
  logic [31:0]  core_wdata, core_rdata, per_wdata, per_rdata;
  logic         per_req, per_wr, per_flag, per_rfull;
  logic [127:0] port_full;
  logic         run_busy;
  logic [2:0]   run_id;
  logic [11:0]  run_pc;

  port_mailbox_sched u_dut (.*);

  int checks = 0, fails = 0;
  logic [31:0]  m_data [8];
  logic [127:0] m_full;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic idle_in;
    cfg_we = 0; core_req = 0; per_req = 0; core_wr = 0; per_wr = 0;
  endtask

  task automatic do_reset;
    idle_in(); rst_n = 0; tick(); tick(); rst_n = 1;
    for (int i = 0; i < 8; i++) m_data[i] = 0;
    m_full = '0;
  endtask

  function automatic bit exp_ok(bit cr, bit cw, logic [6:0] ca, bit pr, logic [6:0] pa, logic [127:0] f);
    if (!cr || (pr && pa == ca)) return 0;
    return cw ? !f[ca] : f[ca];
  endfunction

  task automatic cfg(input int idx, input bit en, input int s, input int e, input logic [127:0] nf, input logic [127:0] ne);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_start = 12'(s); cfg_end = 12'(e);
    cfg_need_full = nf; cfg_need_empty = ne;
    tick(); cfg_we = 0;
  endtask

  task automatic per_write(input int a, input bit f);
    per_req = 1; per_wr = 1; per_addr = 7'(a); per_wdata = 32'hA5A5_0000 + a; per_flag = f;
    tick(); per_req = 0; per_wr = 0;
  endtask

  task automatic chk_run(input bit b, input int id, input int pc, input string req);
    chk(run_busy == b, req, run_busy, b);
    if (b) begin
      chk(run_id == 3'(id), req, run_id, id);
      chk(run_pc == 12'(pc), req, run_pc, pc);
    end
  endtask

  task automatic mbox_op(input bit cr, input bit cw, input int ca, input logic [31:0] cd,
                         input bit pr, input bit pw, input int pa, input logic [31:0] pd, input bit pf);
    bit eo;
    string tag;
    core_req = cr; core_wr = cw; core_addr = 7'(ca); core_wdata = cd;
    per_req = pr; per_wr = pw; per_addr = 7'(pa); per_wdata = pd; per_flag = pf;
    #1;
    eo = exp_ok(cr, cw, 7'(ca), pr, 7'(pa), m_full);
    if (cr && pr && ca == pa) tag = "R7 clash";
    else if (cw) tag = m_full[ca] ? "R3 write-full" : "R2 write-empty";
    else tag = m_full[ca] ? "R4 read-full" : "R5 read-empty";
    if (cr) chk(core_ok == eo, tag, core_ok, eo);
    if (cr && !cw && eo) chk(core_rdata == m_data[ca], "R4 rdata", core_rdata, m_data[ca]);
    if (pr && !pw) begin
      chk(per_rdata == m_data[pa], "R6 per_rdata", per_rdata, m_data[pa]);
      chk(per_rfull == m_full[pa], "R6 per_rfull", per_rfull, m_full[pa]);
    end
    tick();
    if (eo) begin
      if (cw) begin m_data[ca] = cd; m_full[ca] = 1; end
      else m_full[ca] = 0;
    end
    if (pr && pw) begin m_data[pa] = pd; m_full[pa] = pf; end
    chk(port_full == m_full, "R2-flags R3-flags R6-flags", port_full, m_full);
    idle_in();
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    core_addr = 0; core_wdata = 0; per_addr = 0; per_wdata = 0; per_flag = 0;
    cfg_idx = 0; cfg_en = 0; cfg_start = 0; cfg_end = 0; cfg_need_full = 0; cfg_need_empty = 0;
    do_reset();
    chk(port_full == '0, "R1 flags", port_full, 0);
    chk(run_busy == 0, "R1 busy", run_busy, 0);

    mbox_op(1, 0, 2, 0, 0, 0, 0, 0, 0);
    mbox_op(1, 1, 2, 32'h1111, 0, 0, 0, 0, 0);
    mbox_op(1, 1, 2, 32'h2222, 0, 0, 0, 0, 0);
    mbox_op(1, 0, 2, 0, 0, 0, 0, 0, 0);
    mbox_op(1, 1, 3, 32'h3333, 1, 1, 3, 32'h4444, 0);
    mbox_op(0, 0, 0, 0, 1, 0, 3, 0, 0);
    mbox_op(1, 0, 3, 0, 1, 0, 3, 0, 0);

    for (int n = 0; n < 3000; n++)
      mbox_op($urandom_range(1), $urandom_range(1), $urandom_range(7), $urandom,
              $urandom_range(1), $urandom_range(1), $urandom_range(7), $urandom, $urandom_range(1));

    do_reset();
    cfg(3, 1, 10, 12, 128'd1 << 5, 128'd1 << 6);
    cfg(1, 1, 100, 100, (128'd1 << 5) | (128'd1 << 7), '0);
    tick();
    chk_run(0, 0, 0, "R8 unmet condition");
    per_write(5, 1);
    chk_run(0, 0, 0, "R8 flag just set");
    tick(); chk_run(1, 3, 10, "R8 dispatch");
    tick(); chk_run(1, 3, 11, "R9 step");
    per_write(7, 1);
    chk_run(1, 3, 12, "R11 no preempt");
    tick(); chk_run(0, 0, 0, "R9 end idle");
    tick(); chk_run(1, 1, 100, "R10 lowest index");
    tick(); chk_run(0, 0, 0, "R9 single-cycle end");
    tick(); chk_run(1, 1, 100, "R11 redispatch");
    cfg(1, 0, 100, 100, '0, '0);
    chk_run(0, 0, 0, "R12 end");
    tick(); chk_run(1, 3, 10, "R12 disabled skipped");
    per_write(6, 1);
    tick(); tick(); tick();
    chk_run(0, 0, 0, "R8 need-empty blocks");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule